// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block takes the D+ and D- line levels of a low-speed USB link, already sampled by a 20 MHz system clock, and recovers packet bytes from them. While the line is quiet it looks for the end of the sync field. It aligns its bit timing to a J-to-K transition, and it accepts the sync field only when the next bit is also K.

After lock, the block samples each bit near its centre and reads the bit from whether the line changed since the last sample. It drops stuffed bits and shifts the data in least significant bit first. The bit period is 40/3 clocks and is not a whole number of clocks. A fractional accumulator therefore makes every third period one clock longer.

Each completed byte is presented with a one-cycle strobe. A single-ended zero at a sample point closes the packet with a one-cycle end pulse that carries the byte count. If a packet holds more bytes than allowed, it is dropped with an overflow pulse. A single-ended zero that is not followed by a sync edge within a bounded wait is reported as a timeout pulse. This is the usual case for a keep-alive marker.

Top module: `usb_ls_rx`

## Requirements
- R1: After reset, every output is 0, and the block waits with no packet in progress.
- R2: Line encoding is {D+,D-}: J = 01, K = 10, SE0 = 00. A packet starts only when a J-to-K transition is followed, one bit period later, by another K bit. If that later bit is not K, the block resumes hunting for a K edge. The sync field is never output as data.
- R3: A line state equal to the previous sample decodes as 1 and a changed state decodes as 0. Eight decoded bits form one byte, first bit in bit 0. Each byte is presented on byte_data_o with a one-cycle byte_valid_o pulse.
- R4: After six consecutive decoded 1s, the next bit is discarded and the run count restarts. The final K bit of sync counts as the first 1 of a run.
- R5: The first sample is taken 1.5 bit periods after the detected edge. Later samples are spaced BIT_NUM/BIT_DEN clocks apart on average, using periods of floor and ceiling length. This keeps packets of up to MAX_BYTES bytes decoded correctly.
- R6: SE0 at a sample point ends the packet. eop_o pulses for one cycle, and eop_count_o then holds the number of bytes presented, which may be 0.
- R7: When byte MAX_BYTES+1 completes, overflow_o pulses once. No further byte_valid_o pulses follow, and no eop_o is given for that packet.
- R8: A J-to-SE0 transition starts a wait. If no J-to-K edge comes within HUNT_LIMIT clocks, timeout_o pulses once and no bytes are presented. A lone K bit that fails the sync check leads to the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, 20 MHz nominal |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dp_i | input | 1 | Sampled D+ level |
| dm_i | input | 1 | Sampled D- level |
| byte_valid_o | output | 1 | One-cycle strobe for a received byte |
| byte_data_o | output | 8 | Received byte |
| eop_o | output | 1 | One-cycle end-of-packet pulse |
| eop_count_o | output | $clog2(MAX_BYTES+1) | Byte count of the finished packet |
| overflow_o | output | 1 | Packet exceeded MAX_BYTES and was dropped |
| timeout_o | output | 1 | No sync edge within HUNT_LIMIT clocks after SE0 |

## Verification
The bench builds the block with MAX_BYTES = 3 and HUNT_LIMIT = 60. It keeps the default 40/3 bit timing. With a three-byte limit, full-length packets, the overflow on a fourth byte and the empty packet are all short enough to sweep every single-byte value from 0 to 255. That sweep covers every stuffing position that a run starting in the sync field can create. The short hunt limit lets both the keep-alive timeout and a failed sync check time out inside a handful of idle bits. A three-byte packet spans more than 24 bits. A design without the leap clock would drift by more than half a bit over that length, so these packets also test R5.

// File: rtl/usb_ls_rx_pkg.sv
package usb_ls_rx_pkg;
  localparam logic [1:0] LN_SE0 = 2'b00;
  localparam logic [1:0] LN_J   = 2'b01;
  localparam logic [1:0] LN_K   = 2'b10;

  typedef enum logic [1:0] {ST_IDLE, ST_HUNT, ST_CHECK, ST_RECV} rx_state_e;
endpackage

// File: rtl/usb_ls_rx_bit_timer.sv
module usb_ls_rx_bit_timer #(
  parameter int BIT_NUM = 40,
  parameter int BIT_DEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int FIRST  = (3 * BIT_NUM) / (2 * BIT_DEN);
  localparam int PER_LO = BIT_NUM / BIT_DEN;
  localparam int PER_HI = (BIT_NUM + BIT_DEN - 1) / BIT_DEN;
  localparam int CNT_W  = $clog2(FIRST + 1);
  localparam int FRAC_W = $clog2(BIT_DEN + 1);

  logic [CNT_W-1:0]  cnt_q, reload;
  logic [FRAC_W-1:0] frac_q, frac_nx;
  int                total;

  always_comb begin
    total   = BIT_NUM + int'(frac_q);
    reload  = CNT_W'(total / BIT_DEN - 1);
    frac_nx = FRAC_W'(total % BIT_DEN);
  end

  assign tick_o = run_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      frac_q <= '0;
    end else if (start_i) begin
      cnt_q  <= CNT_W'(FIRST - 1);
      frac_q <= '0;
    end else if (run_i) begin
      if (cnt_q == '0) begin
        cnt_q  <= reload;
        frac_q <= frac_nx;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  AST_PERIOD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !start_i) |=> (cnt_q == CNT_W'(PER_LO - 1) || cnt_q == CNT_W'(PER_HI - 1))); // R5
  AST_FRAC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(frac_q) < BIT_DEN); // R5
endmodule

// File: rtl/usb_ls_rx_ctrl.sv
module usb_ls_rx_ctrl
  import usb_ls_rx_pkg::*;
#(
  parameter int HUNT_LIMIT = 200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] line_i,
  input  logic [1:0] line_prev_i,
  input  logic       tick_i,
  input  logic       rx_end_i,
  output logic       timer_start_o,
  output logic       timer_run_o,
  output logic       rx_start_o,
  output logic       rx_active_o,
  output logic       timeout_o
);
  localparam int HW = $clog2(HUNT_LIMIT + 1);

  rx_state_e     state_q, state_d;
  logic [HW-1:0] hunt_q;
  logic          hunt_clr, to_d, jk_edge;

  assign jk_edge = (line_prev_i == LN_J) && (line_i == LN_K);

  always_comb begin
    state_d       = state_q;
    timer_start_o = 1'b0;
    rx_start_o    = 1'b0;
    hunt_clr      = 1'b0;
    to_d          = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (jk_edge) begin
          state_d       = ST_CHECK;
          timer_start_o = 1'b1;
        end else if (line_prev_i == LN_J && line_i == LN_SE0) begin
          state_d  = ST_HUNT;
          hunt_clr = 1'b1;
        end
      end
      ST_HUNT: begin
        if (jk_edge) begin
          state_d       = ST_CHECK;
          timer_start_o = 1'b1;
        end else if (hunt_q == HW'(HUNT_LIMIT - 1)) begin
          state_d = ST_IDLE;
          to_d    = 1'b1;
        end
      end
      ST_CHECK: begin
        if (tick_i) begin
          if (line_i == LN_K) begin
            state_d    = ST_RECV;
            rx_start_o = 1'b1;
          end else begin
            state_d  = ST_HUNT;
            hunt_clr = 1'b1;
          end
        end
      end
      default: begin
        if (rx_end_i) state_d = ST_IDLE;
      end
    endcase
  end

  assign timer_run_o = (state_q == ST_CHECK) || (state_q == ST_RECV);
  assign rx_active_o = (state_q == ST_RECV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      hunt_q    <= '0;
      timeout_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      timeout_o <= to_d;
      if (hunt_clr)                hunt_q <= '0;
      else if (state_q == ST_HUNT) hunt_q <= hunt_q + 1'b1;
    end
  end

  AST_TIMEOUT_FROM_HUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> ($past(state_q) == ST_HUNT && state_q == ST_IDLE)); // R8
  AST_TIMEOUT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o); // R8
  AST_RECV_NEEDS_K: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CHECK && state_d == ST_RECV) |-> line_i == LN_K); // R2
endmodule

// File: rtl/usb_ls_rx_deser.sv
module usb_ls_rx_deser
  import usb_ls_rx_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int CNT_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             sample_i,
  input  logic [1:0]       line_i,
  output logic             end_o,
  output logic             byte_valid_o,
  output logic [7:0]       byte_data_o,
  output logic             eop_o,
  output logic [CNT_W-1:0] eop_count_o,
  output logic             overflow_o
);
  logic [1:0]       prev_q;
  logic [7:0]       shreg_q, shreg_nx;
  logic [2:0]       idx_q, ones_q;
  logic [CNT_W-1:0] cnt_q;
  logic             discard_q, bit_v;

  assign end_o    = sample_i && (line_i == LN_SE0);
  assign bit_v    = (line_i == prev_q);
  assign shreg_nx = {bit_v, shreg_q[7:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q       <= LN_K;
      shreg_q      <= '0;
      idx_q        <= '0;
      ones_q       <= '0;
      cnt_q        <= '0;
      discard_q    <= 1'b0;
      byte_valid_o <= 1'b0;
      byte_data_o  <= '0;
      eop_o        <= 1'b0;
      eop_count_o  <= '0;
      overflow_o   <= 1'b0;
    end else begin
      byte_valid_o <= 1'b0;
      eop_o        <= 1'b0;
      overflow_o   <= 1'b0;
      if (start_i) begin
        prev_q    <= LN_K;
        idx_q     <= '0;
        ones_q    <= 3'd1;  // last sync bit opens the run
        cnt_q     <= '0;
        discard_q <= 1'b0;
      end else if (sample_i) begin
        if (line_i == LN_SE0) begin
          eop_o       <= !discard_q;
          eop_count_o <= cnt_q;
        end else begin
          prev_q <= line_i;
          if (ones_q == 3'd6) begin
            ones_q <= '0;  // stuffed bit dropped
          end else begin
            ones_q  <= bit_v ? ones_q + 1'b1 : '0;
            shreg_q <= shreg_nx;
            idx_q   <= idx_q + 1'b1;
            if (idx_q == 3'd7 && !discard_q) begin
              if (cnt_q == CNT_W'(MAX_BYTES)) begin
                overflow_o <= 1'b1;
                discard_q  <= 1'b1;
              end else begin
                byte_valid_o <= 1'b1;
                byte_data_o  <= shreg_nx;
                cnt_q        <= cnt_q + 1'b1;
              end
            end
          end
        end
      end
    end
  end

  AST_RUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ones_q <= 3'd6); // R4
  AST_VALID_EOP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(byte_valid_o && eop_o)); // R3
  AST_BYTE_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_BYTES)); // R7
  AST_NO_DATA_AFTER_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discard_q |-> !byte_valid_o && !eop_o); // R7
  AST_EOP_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |-> eop_count_o <= CNT_W'(MAX_BYTES)); // R6
endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx
  import usb_ls_rx_pkg::*;
#(
  parameter int BIT_NUM    = 40,
  parameter int BIT_DEN    = 3,
  parameter int MAX_BYTES  = 8,
  parameter int HUNT_LIMIT = 200,
  localparam int CNT_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dp_i,
  input  logic             dm_i,
  output logic             byte_valid_o,
  output logic [7:0]       byte_data_o,
  output logic             eop_o,
  output logic [CNT_W-1:0] eop_count_o,
  output logic             overflow_o,
  output logic             timeout_o
);
  logic [1:0] line_q, line_prev_q;
  logic       tick, t_start, t_run, rx_start, rx_active, rx_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q      <= LN_J;
      line_prev_q <= LN_J;
    end else begin
      line_q      <= {dp_i, dm_i};
      line_prev_q <= line_q;
    end
  end

  usb_ls_rx_bit_timer #(.BIT_NUM(BIT_NUM), .BIT_DEN(BIT_DEN)) i_timer (
    .clk_i, .rst_ni, .start_i(t_start), .run_i(t_run), .tick_o(tick)
  );

  usb_ls_rx_ctrl #(.HUNT_LIMIT(HUNT_LIMIT)) i_ctrl (
    .clk_i, .rst_ni, .line_i(line_q), .line_prev_i(line_prev_q), .tick_i(tick),
    .rx_end_i(rx_end), .timer_start_o(t_start), .timer_run_o(t_run),
    .rx_start_o(rx_start), .rx_active_o(rx_active), .timeout_o
  );

  usb_ls_rx_deser #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) i_deser (
    .clk_i, .rst_ni, .start_i(rx_start), .sample_i(tick && rx_active),
    .line_i(line_q), .end_o(rx_end), .byte_valid_o, .byte_data_o,
    .eop_o, .eop_count_o, .overflow_o
  );

  AST_ONE_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({byte_valid_o, eop_o, overflow_o, timeout_o})); // R6
endmodule

// File: tb/test_usb_ls_rx.sv
`timescale 1ns/1ps
module test_usb_ls_rx;
  localparam int MAXB = 3;
  localparam logic [1:0] J = 2'b01, K = 2'b10, SE0 = 2'b00;

  logic clk = 1'b0, rst_n = 1'b0, dp = 1'b0, dm = 1'b1;
  logic bv, eop, ovf, to;
  logic [7:0] bd;
  logic [1:0] ecnt;

  int checks = 0, errors = 0, bitno = 0;
  bit done = 0;
  logic [7:0] pkt [0:7];
  logic [7:0] rx [0:15];
  int rx_n = 0, eop_n = 0, eop_c = 0, ovf_n = 0, to_n = 0;

  always #2 clk = ~clk;

  usb_ls_rx #(.MAX_BYTES(MAXB), .HUNT_LIMIT(60)) i_usb_ls_rx (
    .clk_i(clk), .rst_ni(rst_n), .dp_i(dp), .dm_i(dm),
    .byte_valid_o(bv), .byte_data_o(bd), .eop_o(eop), .eop_count_o(ecnt),
    .overflow_o(ovf), .timeout_o(to)
  );

  always @(negedge clk) if (rst_n) begin
    if (bv) begin if (rx_n < 16) rx[rx_n] = bd; rx_n++; end
    if (eop) begin eop_n++; eop_c = int'(ecnt); end
    if (ovf) ovf_n++;
    if (to) to_n++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic [1:0] ln);
    int dur;
    {dp, dm} = ln;
    dur = ((bitno + 1) * 40) / 3 - (bitno * 40) / 3;
    bitno++;
    repeat (dur) @(negedge clk);
  endtask

  task automatic clear_mon();
    rx_n = 0; eop_n = 0; eop_c = 0; ovf_n = 0; to_n = 0;
  endtask

  task automatic send_pkt(input int n);
    logic [1:0] cur;
    int ones;
    logic b;
    repeat (3) drive_bit(J);
    drive_bit(K); drive_bit(J); drive_bit(K); drive_bit(J);
    drive_bit(K); drive_bit(J); drive_bit(K); drive_bit(K);
    cur = K; ones = 1;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < 8; j++) begin
        b = pkt[i][j];
        if (!b) cur = (cur == K) ? J : K;
        drive_bit(cur);
        ones = b ? ones + 1 : 0;
        if (ones == 6) begin
          cur = (cur == K) ? J : K;
          drive_bit(cur);
          ones = 0;
        end
      end
    drive_bit(SE0); drive_bit(SE0);
    repeat (4) drive_bit(J);
  endtask

  task automatic check_pkt(input string req, input int n);
    int en = (n > MAXB) ? MAXB : n;
    chk(req, rx_n, en);
    for (int i = 0; i < en && i < rx_n; i++) chk(req, int'(rx[i]), int'(pkt[i]));
    chk(req, eop_n, (n > MAXB) ? 0 : 1);
    if (n <= MAXB) chk(req, eop_c, n);
    chk(req, ovf_n, (n > MAXB) ? 1 : 0);
    chk(req, to_n, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid", int'(bv), 0);
    chk("R1 eop", int'(eop), 0);
    chk("R1 ovf", int'(ovf), 0);
    chk("R1 timeout", int'(to), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3 R4: every single-byte value, stuffing included
    for (int v = 0; v < 256; v++) begin
      clear_mon();
      pkt[0] = 8'(v);
      send_pkt(1);
      check_pkt("R3", 1);
    end

    // R4: long runs of ones
    clear_mon();
    pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'hFF;
    send_pkt(3);
    check_pkt("R4", 3);

    // R5: full-length packets, varied patterns
    for (int k = 0; k < 6; k++) begin
      clear_mon();
      for (int i = 0; i < 3; i++) pkt[i] = 8'((k * 97 + i * 53 + 11) & 255);
      send_pkt(3);
      check_pkt("R5", 3);
    end

    // R6: empty packet
    clear_mon();
    send_pkt(0);
    check_pkt("R6", 0);

    // R7: overflow
    clear_mon();
    pkt[0] = 8'h12; pkt[1] = 8'h34; pkt[2] = 8'h56; pkt[3] = 8'h78;
    send_pkt(4);
    check_pkt("R7", 4);

    // R8: keep-alive SE0 without sync
    clear_mon();
    drive_bit(J); drive_bit(SE0); drive_bit(SE0);
    repeat (10) drive_bit(J);
    chk("R8 timeout", to_n, 1);
    chk("R8 bytes", rx_n, 0);
    chk("R8 eop", eop_n, 0);

    // R2: lone K fails sync check
    clear_mon();
    drive_bit(J); drive_bit(K);
    repeat (12) drive_bit(J);
    chk("R2 timeout", to_n, 1);
    chk("R2 bytes", rx_n, 0);
    chk("R2 eop", eop_n, 0);

    // R2: recovery after failed sync
    clear_mon();
    pkt[0] = 8'hA5;
    send_pkt(1);
    check_pkt("R2", 1);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule